// File: doc/BRIEF.md
# Instruction TLB Replacement Tracker

This block decides which entry a translation cache should overwrite on a refill. It covers two structures. The first is a four-entry, fully associative instruction TLB. For it, the block holds a six-bit pairwise-order word. Every hit or refill of an entry rewrites some bits of that word. A fixed set of masked patterns turns the word into a victim index. A word that matches none of the patterns is flagged as an error.

The second structure is a unified TLB with `UTLB_ENTRIES` entries. For it, the block holds a round-robin replacement counter. The counter moves by one on every unified-TLB access. It returns to zero when it reaches a software-set boundary or the last entry, whichever comes first.

Software loads the order word, the boundary and the counter through one write strobe. In the control word these three fields sit at bits 31:26, 23:18 and 15:10. The port carries the three fields separately. A write always wins over a hardware update of the same fields in the same cycle. The order word, the boundary and the counter are all registered. The victim index and the error flag are decoded from the registered order word without further delay.

Top module: `itlb_repl_tracker`

## Requirements
- R1: After reset the order word, boundary and counter are all zero, so `victim_idx` is 3, `victim_err` is 0 and `urc_value` is 0.
- R2: When order bits [5:3] are all 1, the victim is entry 0. This pattern has the highest priority.
- R3: Otherwise, when bits {5,2,1} equal 0,0,1, the victim is entry 1.
- R4: Otherwise, when bits {4,2,0} equal 0,0,1, the victim is entry 2.
- R5: Otherwise, when bits {3,1,0} are all 0, the victim is entry 3.
- R6: When no pattern matches, `victim_err` is 1 and `victim_idx` is 0.
- R7: A strobe on `hit_valid` rewrites the order word one cycle later, according to `hit_idx`:
  - entry 0 clears bits 5:3;
  - entry 1 sets bit 5 and clears bits 2:1;
  - entry 2 sets bits 4 and 2 and clears bit 0;
  - entry 3 sets bits 3, 1 and 0.
- R8: When `hit_valid` is low, `hit_idx` is ignored and the order word does not change.
- R9: On `utlb_acc`, the counter increments when it equals neither the boundary nor the last entry.
- R10: On `utlb_acc`, a counter equal to the boundary returns to 0.
- R11: On `utlb_acc`, a counter equal to the last entry (63) returns to 0, even when the boundary is below the counter.
- R12: `cfg_we` loads `cfg_lru`, `cfg_urb` and `cfg_urc` on the next edge. This load takes priority over a hit or an access in the same cycle.
- R13: Without `utlb_acc` or `cfg_we`, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Instruction TLB hit or refill strobe |
| hit_idx | input | 2 | Entry that was hit or refilled |
| utlb_acc | input | 1 | Unified TLB access strobe |
| cfg_we | input | 1 | Software write of the three fields |
| cfg_lru | input | 6 | New order word (control bits 31:26) |
| cfg_urb | input | 6 | New counter boundary (control bits 23:18) |
| cfg_urc | input | 6 | New counter value (control bits 15:10) |
| victim_idx | output | 2 | Instruction TLB entry to replace |
| victim_err | output | 1 | Order word matches no victim pattern |
| urc_value | output | 6 | Current unified TLB replacement counter |

## Verification
The victim decode is first driven with one loaded word per pattern. Extra words set bits that an earlier pattern tests, such as all ones or bit 5 together with bit 0. These words show whether the decoder applies the patterns in priority order or as independent matches. A word that matches no pattern separates the error path from a fall-through to entry 3. Hit sequences are then run over all four entries and compared with a bit-level model of the update rules, which exposes any swapped set or clear mask. The counter is run up to a boundary of 5, and separately from 61 with a boundary of 3. These two runs tell the boundary wrap apart from the last-entry wrap.

// File: rtl/itlb_repl_pkg.sv
package itlb_repl_pkg;

    localparam int ORDER_W = 6;
    localparam int WAYS    = 4;
    localparam int WAY_W   = $clog2(WAYS);

    typedef enum logic [2:0] {
        VIC_W0,
        VIC_W1,
        VIC_W2,
        VIC_W3,
        VIC_BAD
    } victim_e;

    typedef enum logic [1:0] {
        ORD_HOLD,
        ORD_LOAD,
        ORD_TOUCH
    } ord_step_e;

    typedef enum logic [1:0] {
        RR_HOLD,
        RR_LOAD,
        RR_WRAP,
        RR_ADV
    } rr_step_e;

endpackage

// File: rtl/itlb_order_reg.sv
module itlb_order_reg
    import itlb_repl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [WAY_W-1:0]   hit_idx,
    input  logic               cfg_we,
    input  logic [ORDER_W-1:0] cfg_lru,
    output logic [ORDER_W-1:0] order_q
);

    ord_step_e          step;
    logic [ORDER_W-1:0] set_mask;
    logic [ORDER_W-1:0] clr_mask;
    logic [ORDER_W-1:0] order_d;

    // Software write outranks a hit in the same cycle.
    always_comb begin
        if (cfg_we)         step = ORD_LOAD;
        else if (hit_valid) step = ORD_TOUCH;
        else                step = ORD_HOLD;
    end

    // Each touched entry has its own set and clear masks.
    always_comb begin
        unique case (hit_idx)
            2'd0: begin set_mask = 6'b000000; clr_mask = 6'b111000; end
            2'd1: begin set_mask = 6'b100000; clr_mask = 6'b000110; end
            2'd2: begin set_mask = 6'b010100; clr_mask = 6'b000001; end
            default: begin set_mask = 6'b001011; clr_mask = 6'b000000; end
        endcase
    end

    always_comb begin
        unique case (step)
            ORD_LOAD:  order_d = cfg_lru;
            ORD_TOUCH: order_d = (order_q & ~clr_mask) | set_mask;
            default:   order_d = order_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) order_q <= '0;
        else        order_q <= order_d;
    end

endmodule

// File: rtl/itlb_victim_dec.sv
module itlb_victim_dec
    import itlb_repl_pkg::*;
(
    input  logic [ORDER_W-1:0] order_q,
    output victim_e            victim
);

    logic pick0, pick1, pick2, pick3;

    always_comb begin
        pick0 = &order_q[5:3];
        pick1 = ({order_q[5], order_q[2], order_q[1]} == 3'b001);
        pick2 = ({order_q[4], order_q[2], order_q[0]} == 3'b001);
        pick3 = ({order_q[3], order_q[1], order_q[0]} == 3'b000);
    end

    // The patterns are tested in a fixed order; the first one that matches wins.
    always_comb begin
        if (pick0)      victim = VIC_W0;
        else if (pick1) victim = VIC_W1;
        else if (pick2) victim = VIC_W2;
        else if (pick3) victim = VIC_W3;
        else            victim = VIC_BAD;
    end

endmodule

// File: rtl/utlb_rr_counter.sv
module utlb_rr_counter
    import itlb_repl_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int CNT_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_urb,
    input  logic [CNT_W-1:0] cfg_urc,
    output logic [CNT_W-1:0] urc_q,
    output logic [CNT_W-1:0] urb_q
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRIES - 1);

    rr_step_e         step;
    logic [CNT_W-1:0] urc_d;
    logic [CNT_W-1:0] urb_d;

    always_comb begin
        if (cfg_we)                               step = RR_LOAD;
        else if (!acc)                            step = RR_HOLD;
        else if (urc_q == urb_q || urc_q == LAST) step = RR_WRAP;
        else                                      step = RR_ADV;
    end

    always_comb begin
        urb_d = urb_q;
        unique case (step)
            RR_LOAD: begin urc_d = cfg_urc; urb_d = cfg_urb; end
            RR_WRAP: urc_d = '0;
            RR_ADV:  urc_d = urc_q + 1'b1;
            default: urc_d = urc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urc_q <= '0;
            urb_q <= '0;
        end else begin
            urc_q <= urc_d;
            urb_q <= urb_d;
        end
    end

endmodule

// File: rtl/itlb_repl_tracker.sv
module itlb_repl_tracker
    import itlb_repl_pkg::*;
#(
    parameter int UTLB_ENTRIES = 64,
    parameter int CNT_W        = $clog2(UTLB_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [WAY_W-1:0]   hit_idx,
    input  logic               utlb_acc,
    input  logic               cfg_we,
    input  logic [ORDER_W-1:0] cfg_lru,
    input  logic [CNT_W-1:0]   cfg_urb,
    input  logic [CNT_W-1:0]   cfg_urc,
    output logic [WAY_W-1:0]   victim_idx,
    output logic               victim_err,
    output logic [CNT_W-1:0]   urc_value
);

    logic [ORDER_W-1:0] lru_q;
    logic [CNT_W-1:0]   urb_q;
    victim_e            victim;

    itlb_order_reg u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .hit_idx   (hit_idx),
        .cfg_we    (cfg_we),
        .cfg_lru   (cfg_lru),
        .order_q   (lru_q)
    );

    itlb_victim_dec u_dec (
        .order_q (lru_q),
        .victim  (victim)
    );

    utlb_rr_counter #(
        .ENTRIES (UTLB_ENTRIES),
        .CNT_W   (CNT_W)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (utlb_acc),
        .cfg_we  (cfg_we),
        .cfg_urb (cfg_urb),
        .cfg_urc (cfg_urc),
        .urc_q   (urc_value),
        .urb_q   (urb_q)
    );

    // Map the decoded victim onto the output pins.
    always_comb begin
        victim_err = 1'b0;
        unique case (victim)
            VIC_W0:  victim_idx = 2'd0;
            VIC_W1:  victim_idx = 2'd1;
            VIC_W2:  victim_idx = 2'd2;
            VIC_W3:  victim_idx = 2'd3;
            default: begin victim_idx = 2'd0; victim_err = 1'b1; end
        endcase
    end

endmodule

// File: rtl/itlb_repl_checker.sv
module itlb_repl_checker #(
    parameter int UTLB_ENTRIES = 64,
    parameter int CNT_W        = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_valid,
    input logic [1:0]       hit_idx,
    input logic             utlb_acc,
    input logic             cfg_we,
    input logic [5:0]       cfg_lru,
    input logic [CNT_W-1:0] cfg_urc,
    input logic [5:0]       lru_q,
    input logic [CNT_W-1:0] urb_q,
    input logic [CNT_W-1:0] urc_value,
    input logic [1:0]       victim_idx,
    input logic             victim_err
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(UTLB_ENTRIES - 1);

    a_r2_all_newer_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (&lru_q[5:3]) |-> (victim_idx == 2'd0 && !victim_err));

    a_r6_error_reports_zero: assert property (@(posedge clk) disable iff (!rst_n)
        victim_err |-> victim_idx == 2'd0);

    a_r7_touch0_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_idx == 2'd0 && !cfg_we) |=> lru_q[5:3] == 3'b000);

    a_r8_order_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_valid && !cfg_we) |=> $stable(lru_q));

    a_r9_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (utlb_acc && !cfg_we && urc_value != urb_q && urc_value != LAST)
        |=> urc_value == $past(urc_value) + 1'b1);

    a_r10_counter_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (utlb_acc && !cfg_we && (urc_value == urb_q || urc_value == LAST))
        |=> urc_value == '0);

    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (urc_value == $past(cfg_urc) && lru_q == $past(cfg_lru)));

    a_r13_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!utlb_acc && !cfg_we) |=> $stable(urc_value));

endmodule

bind itlb_repl_tracker itlb_repl_checker #(
    .UTLB_ENTRIES (UTLB_ENTRIES),
    .CNT_W        (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .hit_idx    (hit_idx),
    .utlb_acc   (utlb_acc),
    .cfg_we     (cfg_we),
    .cfg_lru    (cfg_lru),
    .cfg_urc    (cfg_urc),
    .lru_q      (lru_q),
    .urb_q      (urb_q),
    .urc_value  (urc_value),
    .victim_idx (victim_idx),
    .victim_err (victim_err)
);

// File: tb/itlb_repl_tracker_test.sv
module itlb_repl_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_valid = 1'b0;
    logic [1:0] hit_idx = 2'd0;
    logic       utlb_acc = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_lru = '0;
    logic [5:0] cfg_urb = '0;
    logic [5:0] cfg_urc = '0;
    logic [1:0] victim_idx;
    logic       victim_err;
    logic [5:0] urc_value;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    itlb_repl_tracker uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_valid  (hit_valid),
        .hit_idx    (hit_idx),
        .utlb_acc   (utlb_acc),
        .cfg_we     (cfg_we),
        .cfg_lru    (cfg_lru),
        .cfg_urb    (cfg_urb),
        .cfg_urc    (cfg_urc),
        .victim_idx (victim_idx),
        .victim_err (victim_err),
        .urc_value  (urc_value)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Victim rule model: returns {err, idx}.
    function automatic logic [2:0] model_victim(input logic [5:0] w);
        if (&w[5:3])                          return 3'b000;
        if ({w[5], w[2], w[1]} == 3'b001)     return 3'b001;
        if ({w[4], w[2], w[0]} == 3'b001)     return 3'b010;
        if ({w[3], w[1], w[0]} == 3'b000)     return 3'b011;
        return 3'b100;
    endfunction

    function automatic logic [5:0] model_touch(input logic [5:0] w, input logic [1:0] e);
        case (e)
            2'd0:    return w & 6'b000111;
            2'd1:    return (w & 6'b111001) | 6'b100000;
            2'd2:    return (w & 6'b111110) | 6'b010100;
            default: return w | 6'b001011;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [5:0] l, input logic [5:0] b, input logic [5:0] c);
        cfg_we = 1'b1; cfg_lru = l; cfg_urb = b; cfg_urc = c;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 victim_idx", victim_idx, 3);
        chk("R1 victim_err", victim_err, 0);
        chk("R1 urc_value", urc_value, 0);
    endtask

    task automatic t_patterns();
        cfg_write(6'b111000, 0, 0);
        chk("R2 victim", victim_idx, 0);
        chk("R2 err", victim_err, 0);
        cfg_write(6'b111111, 0, 0);
        chk("R2 priority all ones", victim_idx, 0);
        cfg_write(6'b000010, 0, 0);
        chk("R3 victim", victim_idx, 1);
        cfg_write(6'b000001, 0, 0);
        chk("R4 victim", victim_idx, 2);
        cfg_write(6'b100001, 0, 0);
        chk("R4 victim with bit5", victim_idx, 2);
        cfg_write(6'b000000, 0, 0);
        chk("R5 victim", victim_idx, 3);
        chk("R5 err", victim_err, 0);
    endtask

    task automatic t_invalid();
        cfg_write(6'b000110, 0, 0);
        chk("R6 err", victim_err, 1);
        chk("R6 idx", victim_idx, 0);
    endtask

    task automatic t_hits();
        logic [5:0] m;
        logic [2:0] v;
        logic [1:0] seq [8] = '{2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd0, 2'd2};
        cfg_write(6'b000000, 0, 0);
        hit_valid = 1'b1; hit_idx = 2'd3;
        tick();
        hit_valid = 1'b0;
        chk("R7 touch3 from zero", victim_idx, 1);
        cfg_write(6'b111111, 0, 0);
        hit_valid = 1'b1; hit_idx = 2'd0;
        tick();
        hit_valid = 1'b0;
        chk("R7 touch0 from ones err", victim_err, 1);
        m = 6'b000000;
        cfg_write(m, 0, 0);
        for (int i = 0; i < 8; i++) begin
            hit_valid = 1'b1; hit_idx = seq[i];
            m = model_touch(m, seq[i]);
            tick();
            v = model_victim(m);
            chk("R7 seq idx", victim_idx, int'(v[1:0]));
            chk("R7 seq err", victim_err, int'(v[2]));
        end
        hit_valid = 1'b0;
    endtask

    task automatic t_no_hit();
        cfg_write(6'b000010, 0, 0);
        for (int i = 0; i < 4; i++) begin
            hit_idx = 2'(i);
            tick();
        end
        chk("R8 ignored hit_idx", victim_idx, 1);
        chk("R8 ignored err", victim_err, 0);
    endtask

    task automatic t_urc_boundary();
        cfg_write(0, 6'd5, 6'd0);
        utlb_acc = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            tick();
            chk("R9 advance", urc_value, i);
        end
        tick();
        chk("R10 wrap at boundary", urc_value, 0);
        tick();
        chk("R9 advance after wrap", urc_value, 1);
        utlb_acc = 1'b0;
    endtask

    task automatic t_urc_last();
        cfg_write(0, 6'd3, 6'd61);
        utlb_acc = 1'b1;
        tick();
        chk("R11 step to 62", urc_value, 62);
        tick();
        chk("R11 step to 63", urc_value, 63);
        tick();
        chk("R11 wrap at last", urc_value, 0);
        utlb_acc = 1'b0;
    endtask

    task automatic t_urc_hold();
        cfg_write(0, 6'd40, 6'd17);
        tick(); tick(); tick();
        chk("R13 hold", urc_value, 17);
    endtask

    task automatic t_priority();
        cfg_write(6'b000000, 6'd40, 6'd10);
        cfg_we = 1'b1; cfg_lru = 6'b000001; cfg_urb = 6'd40; cfg_urc = 6'd30;
        hit_valid = 1'b1; hit_idx = 2'd0; utlb_acc = 1'b1;
        tick();
        cfg_we = 1'b0; hit_valid = 1'b0; utlb_acc = 1'b0;
        chk("R12 urc loaded", urc_value, 30);
        chk("R12 order loaded", victim_idx, 2);
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_invalid();
        t_hits();
        t_no_hit();
        t_urc_boundary();
        t_urc_last();
        t_urc_hold();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule